// File: doc/BRIEF.md
# Zero-Value Tag Cache Controller

This block sits in front of a first-level data cache and answers load lookups without holding any data. Each entry records a block tag, a valid flag, one zero flag per word of the block and one residency flag per lower-level sub-block. A lookup whose word is known to be zero completes at once with the value zero. Any other lookup is reported as a miss of one of two kinds, together with a routing hint that says whether the next level of cache or main memory should serve it.

Entries are created only by fills that come back from the second-level cache or from memory. A lookup that misses never allocates. Stores of non-zero values clear the matching zero flag. Speculative zero stores may set a flag early; the prior flag value goes into an undo log. A commit drops the logged records for a speculation ID, and a squash writes their saved values back.

All addresses on the ports are word addresses of `WADDR_W` bits: bits [3:0] select the word in the block, bits [3:2] select the 16-byte sub-block, bits [5:4] select the set and bits [29:6] are the tag. `fill_zero_i[k]` belongs to word k and `fill_cib_i[j]` belongs to sub-block j.

Top module: `zvc_ctrl`

## Requirements
- R1: After reset every entry is invalid, no response is pending, and any lookup reports an entry miss routed to the second level (`rsp_to_mem_o`=0).
- R2: `rsp_valid_o` is high in exactly the cycle that follows a cycle with `lk_valid_i` high, and low otherwise.
- R3: A lookup whose tag matches a valid entry whose zero flag for the word is set reports kind 0 (hit) with `rsp_to_mem_o`=0.
- R4: A lookup whose tag matches but whose zero flag is clear reports kind 1 (data miss).
- R5: A lookup matching no valid entry reports kind 2 (entry miss), and repeating it still reports an entry miss: lookups never allocate.
- R6: `rsp_to_mem_o` is 1 only for a data miss whose entry has the residency flag of the addressed sub-block clear; entry misses, hits and data misses with the flag set give 0.
- R7: A fill writes tag, zero flags and residency flags into the way already holding that tag, else the lowest-numbered invalid way, and never leaves two valid ways of a set with the same tag.
- R8: A fill into a full set replaces the least recently used way, where a use is a fill or a lookup that matches the tag.
- R9: A non-zero store to a present block clears that word's zero flag; a non-zero store to an absent block and a non-speculative zero store change nothing.
- R10: A speculative zero store to a present block sets the word's zero flag and logs its prior value under the store's speculation ID.
- R11: A squash restores every flag logged under its ID, replayed youngest first so that the oldest saved value wins, and leaves records of other IDs untouched.
- R12: A commit discards the records of its ID without touching any flag; a later squash of that ID has no effect.
- R13: With `LOG_DEPTH` records already held, a speculative zero store is not applied.
- R14: A fill into a way discards every log record pointing at that way, so a later squash cannot alter the new block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lk_valid_i | input | 1 | Load lookup request |
| lk_addr_i | input | WADDR_W | Lookup word address |
| rsp_valid_o | output | 1 | Lookup result valid |
| rsp_kind_o | output | 2 | 0 hit, 1 data miss, 2 entry miss |
| rsp_to_mem_o | output | 1 | Miss goes straight to memory |
| fill_valid_i | input | 1 | Fill from second level or memory |
| fill_addr_i | input | WADDR_W | Any word address inside the filled block |
| fill_zero_i | input | WORDS | Zero flags for the block |
| fill_cib_i | input | SUBS | Residency flags per sub-block |
| st_valid_i | input | 1 | Store notification |
| st_addr_i | input | WADDR_W | Store word address |
| st_nonzero_i | input | 1 | Stored value is non-zero |
| st_spec_i | input | 1 | Store is not yet committed |
| st_id_i | input | ID_W | Speculation ID of the store |
| commit_valid_i | input | 1 | Commit a speculation ID |
| commit_id_i | input | ID_W | ID being committed |
| squash_valid_i | input | 1 | Squash a speculation ID |
| squash_id_i | input | ID_W | ID being squashed |

## Verification
Every corrupted flag or tag in this block surfaces on the next lookup of the affected word: a stale zero flag turns a data miss into a hit one cycle after the request, a lost flag turns a hit into a miss, and a wrong residency flag flips the routing bit. Undo-log faults stay hidden until a squash, so each squash is followed immediately by lookups of all words it could touch, including words logged twice and words logged under a different ID. Replacement faults appear as an entry miss on the block that should have survived a fill into a full set.

// File: rtl/zvc_pkg.sv
package zvc_pkg;
  typedef enum logic [1:0] {
    RSP_HIT        = 2'd0,
    RSP_DATA_MISS  = 2'd1,
    RSP_ENTRY_MISS = 2'd2
  } rsp_kind_e;
endpackage

// File: rtl/zvc_lru.sv
module zvc_lru #(
  parameter int SETS  = 4,
  parameter int WAYS  = 2,
  localparam int SET_W = (SETS > 1) ? $clog2(SETS) : 1,
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             touch_i,
  input  logic [SET_W-1:0] touch_set_i,
  input  logic [WAY_W-1:0] touch_way_i,
  input  logic [SET_W-1:0] query_set_i,
  output logic [WAY_W-1:0] victim_o
);
  localparam int AGE_W = WAY_W;
  localparam logic [AGE_W-1:0] OLDEST = AGE_W'(WAYS - 1);

  logic [AGE_W-1:0] age_q [SETS][WAYS];

  // age 0 = most recent; ages in a set stay a permutation
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++)
          age_q[s][w] <= AGE_W'(w);
    end else if (touch_i) begin
      for (int w = 0; w < WAYS; w++) begin
        if (WAY_W'(w) == touch_way_i)
          age_q[touch_set_i][w] <= '0;
        else if (age_q[touch_set_i][w] < age_q[touch_set_i][touch_way_i])
          age_q[touch_set_i][w] <= age_q[touch_set_i][w] + 1'b1;
      end
    end
  end

  always_comb begin
    victim_o = '0;
    for (int w = 0; w < WAYS; w++)
      if (age_q[query_set_i][w] == OLDEST) victim_o = WAY_W'(w);
  end

  for (genvar s = 0; s < SETS; s++) begin : g_chk
    logic [WAYS-1:0] is_old;
    for (genvar w = 0; w < WAYS; w++) begin : g_w
      assign is_old[w] = (age_q[s][w] == OLDEST);
    end
    AST_LRU_ONE_VICTIM: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $countones(is_old) == 1); // R8
  end
endmodule

// File: rtl/zvc_undo_log.sv
module zvc_undo_log #(
  parameter int DEPTH = 8,
  parameter int ID_W  = 3,
  parameter int KEY_W = 3,
  parameter int PAY_W = 5,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        push_i,
  input  logic [ID_W-1:0]             push_id_i,
  input  logic [KEY_W-1:0]            push_key_i,
  input  logic [PAY_W-1:0]            push_pay_i,
  output logic                        full_o,
  input  logic                        commit_i,
  input  logic [ID_W-1:0]             commit_id_i,
  input  logic                        squash_i,
  input  logic [ID_W-1:0]             squash_id_i,
  input  logic                        kill_i,
  input  logic [KEY_W-1:0]            kill_key_i,
  output logic [DEPTH-1:0]            rest_vld_o,
  output logic [DEPTH-1:0][KEY_W-1:0] rest_key_o,
  output logic [DEPTH-1:0][PAY_W-1:0] rest_pay_o
);
  // index 0 holds the oldest record
  logic [DEPTH-1:0][ID_W-1:0]  id_q,  id_d;
  logic [DEPTH-1:0][KEY_W-1:0] key_q, key_d;
  logic [DEPTH-1:0][PAY_W-1:0] pay_q, pay_d;
  logic [CNT_W-1:0]            cnt_q, cnt_d;
  logic [DEPTH-1:0]            live, keep;

  assign full_o = (cnt_q == CNT_W'(DEPTH));

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      live[i] = CNT_W'(i) < cnt_q;
      keep[i] = live[i]
              && !(commit_i && id_q[i] == commit_id_i)
              && !(squash_i && id_q[i] == squash_id_i)
              && !(kill_i && key_q[i] == kill_key_i);
      rest_vld_o[i] = live[i] && squash_i && id_q[i] == squash_id_i;
    end
  end
  assign rest_key_o = key_q;
  assign rest_pay_o = pay_q;

  always_comb begin
    int k;
    k     = 0;
    id_d  = '0;
    key_d = '0;
    pay_d = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (keep[i]) begin
        id_d[k]  = id_q[i];
        key_d[k] = key_q[i];
        pay_d[k] = pay_q[i];
        k++;
      end
    end
    if (push_i && !full_o && k < DEPTH) begin
      id_d[k]  = push_id_i;
      key_d[k] = push_key_i;
      pay_d[k] = push_pay_i;
      k++;
    end
    cnt_d = CNT_W'(k);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      id_q  <= '0;
      key_q <= '0;
      pay_q <= '0;
      cnt_q <= '0;
    end else begin
      id_q  <= id_d;
      key_q <= key_d;
      pay_q <= pay_d;
      cnt_q <= cnt_d;
    end
  end

  AST_LOG_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(DEPTH)); // R13
  AST_LOG_FULL_REJECTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i && full_o && !commit_i && !squash_i && !kill_i |=> full_o); // R13
  AST_COMMIT_SHRINKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_i && !push_i |=> cnt_q <= $past(cnt_q)); // R12
endmodule

// File: rtl/zvc_ctrl.sv
module zvc_ctrl
  import zvc_pkg::*;
#(
  parameter int WADDR_W    = 30,
  parameter int SETS       = 4,
  parameter int WAYS       = 2,
  parameter int WORDS      = 16,
  parameter int SUBS       = 4,
  parameter int LOG_DEPTH  = 8,
  parameter int ID_W       = 3,
  localparam int WORD_W = $clog2(WORDS),
  localparam int SUB_W  = (SUBS > 1) ? $clog2(SUBS) : 1,
  localparam int SET_W  = (SETS > 1) ? $clog2(SETS) : 1,
  localparam int WAY_W  = (WAYS > 1) ? $clog2(WAYS) : 1,
  localparam int TAG_W  = WADDR_W - WORD_W - SET_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               lk_valid_i,
  input  logic [WADDR_W-1:0] lk_addr_i,
  output logic               rsp_valid_o,
  output logic [1:0]         rsp_kind_o,
  output logic               rsp_to_mem_o,
  input  logic               fill_valid_i,
  input  logic [WADDR_W-1:0] fill_addr_i,
  input  logic [WORDS-1:0]   fill_zero_i,
  input  logic [SUBS-1:0]    fill_cib_i,
  input  logic               st_valid_i,
  input  logic [WADDR_W-1:0] st_addr_i,
  input  logic               st_nonzero_i,
  input  logic               st_spec_i,
  input  logic [ID_W-1:0]    st_id_i,
  input  logic               commit_valid_i,
  input  logic [ID_W-1:0]    commit_id_i,
  input  logic               squash_valid_i,
  input  logic [ID_W-1:0]    squash_id_i
);
  localparam int KEY_W = SET_W + WAY_W;
  localparam int PAY_W = WORD_W + 1;

  logic               valid_q [SETS][WAYS];
  logic [TAG_W-1:0]   tag_q   [SETS][WAYS];
  logic [WORDS-1:0]   zero_q  [SETS][WAYS];
  logic [SUBS-1:0]    cib_q   [SETS][WAYS];

  // ---------------- lookup ----------------
  logic [SET_W-1:0]  lk_set;
  logic [TAG_W-1:0]  lk_tag;
  logic [WORD_W-1:0] lk_word;
  logic [SUB_W-1:0]  lk_sub;
  logic [WAY_W-1:0]  lk_way;
  logic              lk_any, lk_zbit, lk_cbit;
  rsp_kind_e         kind_d, kind_q;
  logic              mem_d, mem_q, rsp_q;

  assign lk_word = lk_addr_i[WORD_W-1:0];
  assign lk_sub  = lk_addr_i[WORD_W-1 -: SUB_W];
  assign lk_set  = lk_addr_i[WORD_W +: SET_W];
  assign lk_tag  = lk_addr_i[WORD_W+SET_W +: TAG_W];

  always_comb begin
    lk_any = 1'b0;
    lk_way = '0;
    for (int w = 0; w < WAYS; w++)
      if (valid_q[lk_set][w] && tag_q[lk_set][w] == lk_tag) begin
        lk_any = 1'b1;
        lk_way = WAY_W'(w);
      end
    lk_zbit = zero_q[lk_set][lk_way][lk_word];
    lk_cbit = cib_q[lk_set][lk_way][lk_sub];
    if (!lk_any)      kind_d = RSP_ENTRY_MISS;
    else if (lk_zbit) kind_d = RSP_HIT;
    else              kind_d = RSP_DATA_MISS;
    mem_d = lk_any && !lk_zbit && !lk_cbit;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_q  <= 1'b0;
      kind_q <= RSP_ENTRY_MISS;
      mem_q  <= 1'b0;
    end else begin
      rsp_q <= lk_valid_i;
      if (lk_valid_i) begin
        kind_q <= kind_d;
        mem_q  <= mem_d;
      end
    end
  end

  assign rsp_valid_o  = rsp_q;
  assign rsp_kind_o   = kind_q;
  assign rsp_to_mem_o = mem_q;

  // ---------------- store ----------------
  logic [SET_W-1:0]  st_set;
  logic [TAG_W-1:0]  st_tag;
  logic [WORD_W-1:0] st_word;
  logic [WAY_W-1:0]  st_way;
  logic              st_any, st_old, spec_push, log_full;

  assign st_word = st_addr_i[WORD_W-1:0];
  assign st_set  = st_addr_i[WORD_W +: SET_W];
  assign st_tag  = st_addr_i[WORD_W+SET_W +: TAG_W];

  always_comb begin
    st_any = 1'b0;
    st_way = '0;
    for (int w = 0; w < WAYS; w++)
      if (valid_q[st_set][w] && tag_q[st_set][w] == st_tag) begin
        st_any = 1'b1;
        st_way = WAY_W'(w);
      end
    st_old = zero_q[st_set][st_way][st_word];
  end

  assign spec_push = st_valid_i && st_any && !st_nonzero_i && st_spec_i && !log_full;

  // ---------------- fill ----------------
  logic [SET_W-1:0] f_set;
  logic [TAG_W-1:0] f_tag;
  logic [WAY_W-1:0] f_hit_way, f_inv_way, f_victim, f_way;
  logic             f_hit, f_inv;

  assign f_set = fill_addr_i[WORD_W +: SET_W];
  assign f_tag = fill_addr_i[WORD_W+SET_W +: TAG_W];

  always_comb begin
    f_hit     = 1'b0;
    f_hit_way = '0;
    f_inv     = 1'b0;
    f_inv_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (valid_q[f_set][w] && tag_q[f_set][w] == f_tag) begin
        f_hit     = 1'b1;
        f_hit_way = WAY_W'(w);
      end
      if (!valid_q[f_set][w]) begin
        f_inv     = 1'b1;
        f_inv_way = WAY_W'(w);
      end
    end
    if (f_hit)      f_way = f_hit_way;
    else if (f_inv) f_way = f_inv_way;
    else            f_way = f_victim;
  end

  zvc_lru #(
    .SETS (SETS),
    .WAYS (WAYS)
  ) u_lru (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .touch_i     (fill_valid_i || (lk_valid_i && lk_any)),
    .touch_set_i (fill_valid_i ? f_set : lk_set),
    .touch_way_i (fill_valid_i ? f_way : lk_way),
    .query_set_i (f_set),
    .victim_o    (f_victim)
  );

  // ---------------- undo log ----------------
  logic [LOG_DEPTH-1:0]            rest_vld;
  logic [LOG_DEPTH-1:0][KEY_W-1:0] rest_key;
  logic [LOG_DEPTH-1:0][PAY_W-1:0] rest_pay;

  zvc_undo_log #(
    .DEPTH (LOG_DEPTH),
    .ID_W  (ID_W),
    .KEY_W (KEY_W),
    .PAY_W (PAY_W)
  ) u_log (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_i      (spec_push),
    .push_id_i   (st_id_i),
    .push_key_i  ({st_set, st_way}),
    .push_pay_i  ({st_word, st_old}),
    .full_o      (log_full),
    .commit_i    (commit_valid_i),
    .commit_id_i (commit_id_i),
    .squash_i    (squash_valid_i),
    .squash_id_i (squash_id_i),
    .kill_i      (fill_valid_i),
    .kill_key_i  ({f_set, f_way}),
    .rest_vld_o  (rest_vld),
    .rest_key_o  (rest_key),
    .rest_pay_o  (rest_pay)
  );

  // ---------------- state update ----------------
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++) begin
          valid_q[s][w] <= 1'b0;
          tag_q[s][w]   <= '0;
          zero_q[s][w]  <= '0;
          cib_q[s][w]   <= '0;
        end
    end else begin
      if (fill_valid_i) begin
        valid_q[f_set][f_way] <= 1'b1;
        tag_q[f_set][f_way]   <= f_tag;
        zero_q[f_set][f_way]  <= fill_zero_i;
        cib_q[f_set][f_way]   <= fill_cib_i;
      end
      if (st_valid_i && st_any && st_nonzero_i)
        zero_q[st_set][st_way][st_word] <= 1'b0;
      else if (spec_push)
        zero_q[st_set][st_way][st_word] <= 1'b1;
      // youngest applied first, oldest write lands last
      for (int i = LOG_DEPTH - 1; i >= 0; i--)
        if (rest_vld[i])
          zero_q[rest_key[i][WAY_W +: SET_W]][rest_key[i][WAY_W-1:0]][rest_pay[i][PAY_W-1:1]]
            <= rest_pay[i][0];
    end
  end

  // ---------------- assertions ----------------
  AST_RSP_AFTER_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_valid_i |=> rsp_valid_o); // R2
  AST_NO_STRAY_RSP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lk_valid_i |=> !rsp_valid_o); // R2
  AST_HIT_NOT_TO_MEM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && rsp_kind_o == RSP_HIT |-> !rsp_to_mem_o); // R6
  AST_EMISS_NOT_TO_MEM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && rsp_kind_o == RSP_ENTRY_MISS |-> !rsp_to_mem_o); // R6
  AST_NZ_STORE_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_valid_i && st_any && st_nonzero_i && !fill_valid_i && !squash_valid_i
      |=> !zero_q[$past(st_set)][$past(st_way)][$past(st_word)]); // R9

  for (genvar s = 0; s < SETS; s++) begin : g_uniq
    for (genvar a = 0; a < WAYS; a++) begin : g_a
      for (genvar b = a + 1; b < WAYS; b++) begin : g_b
        AST_TAG_UNIQUE: assert property (@(posedge clk_i) disable iff (!rst_ni)
          !(valid_q[s][a] && valid_q[s][b] && tag_q[s][a] == tag_q[s][b])); // R7
      end
    end
  end
endmodule

// File: tb/zvc_ctrl_tb_top.sv
module zvc_ctrl_tb_top;
  localparam int WADDR_W = 30;
  localparam logic [1:0] K_HIT = 2'd0, K_DM = 2'd1, K_EM = 2'd2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic lk_valid = 0, fill_valid = 0, st_valid = 0, st_nz = 0, st_spec = 0;
  logic commit_valid = 0, squash_valid = 0;
  logic [WADDR_W-1:0] lk_addr = '0, fill_addr = '0, st_addr = '0;
  logic [15:0] fill_zero = '0;
  logic [3:0]  fill_cib = '0;
  logic [2:0]  st_id = '0, commit_id = '0, squash_id = '0;
  logic rsp_valid, rsp_mem;
  logic [1:0] rsp_kind;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [1:0] exp_kind_q[$];
  logic       exp_mem_q[$];
  string      exp_req_q[$];

  always #10 clk = ~clk;

  zvc_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .lk_valid_i(lk_valid), .lk_addr_i(lk_addr),
    .rsp_valid_o(rsp_valid), .rsp_kind_o(rsp_kind), .rsp_to_mem_o(rsp_mem),
    .fill_valid_i(fill_valid), .fill_addr_i(fill_addr),
    .fill_zero_i(fill_zero), .fill_cib_i(fill_cib),
    .st_valid_i(st_valid), .st_addr_i(st_addr), .st_nonzero_i(st_nz),
    .st_spec_i(st_spec), .st_id_i(st_id),
    .commit_valid_i(commit_valid), .commit_id_i(commit_id),
    .squash_valid_i(squash_valid), .squash_id_i(squash_id)
  );

  function automatic logic [WADDR_W-1:0] mk(int tag, int set, int word);
    return {tag[23:0], set[1:0], word[3:0]};
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic lookup(int tag, int set, int word, logic [1:0] k, logic m, string req);
    @(negedge clk);
    lk_valid = 1; lk_addr = mk(tag, set, word);
    exp_kind_q.push_back(k); exp_mem_q.push_back(m); exp_req_q.push_back(req);
    @(negedge clk);
    lk_valid = 0;
  endtask

  task automatic fill(int tag, int set, logic [15:0] z, logic [3:0] c);
    @(negedge clk);
    fill_valid = 1; fill_addr = mk(tag, set, 0); fill_zero = z; fill_cib = c;
    @(negedge clk);
    fill_valid = 0;
  endtask

  task automatic store(int tag, int set, int word, logic nz, logic spec, logic [2:0] id);
    @(negedge clk);
    st_valid = 1; st_addr = mk(tag, set, word); st_nz = nz; st_spec = spec; st_id = id;
    @(negedge clk);
    st_valid = 0;
  endtask

  task automatic commit(logic [2:0] id);
    @(negedge clk); commit_valid = 1; commit_id = id;
    @(negedge clk); commit_valid = 0;
  endtask

  task automatic squash(logic [2:0] id);
    @(negedge clk); squash_valid = 1; squash_id = id;
    @(negedge clk); squash_valid = 0;
  endtask

  task automatic report;
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (exp_kind_q.size() == 0) begin
        check(0, "R2 unexpected response", 1, 0);
      end else begin
        logic [1:0] k;
        logic m;
        string r;
        k = exp_kind_q.pop_front(); m = exp_mem_q.pop_front(); r = exp_req_q.pop_front();
        check(rsp_kind == k && rsp_mem == m, r, {rsp_kind, rsp_mem}, {k, m});
      end
    end
  end

  initial begin
    #(20 * 20000);
    check(0, "watchdog", 0, 1);
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    check(rsp_valid == 0, "R1 reset idle", rsp_valid, 0);
    rst_n = 1;
    // R1 / R5
    lookup(1, 0, 0, K_EM, 0, "R1 empty lookup");
    lookup(1, 0, 0, K_EM, 0, "R5 no allocate");
    fill(1, 0, 16'h0005, 4'b0001);
    lookup(1, 0, 0, K_HIT, 0, "R3 hit");
    lookup(1, 0, 1, K_DM, 0, "R4 data miss cib set");
    lookup(1, 0, 4, K_DM, 1, "R6 data miss to memory");
    // R9
    store(1, 0, 2, 1, 0, 0);
    lookup(1, 0, 2, K_DM, 0, "R9 nonzero store clears");
    store(1, 0, 1, 0, 0, 0);
    lookup(1, 0, 1, K_DM, 0, "R9 committed zero store ignored");
    store(9, 0, 0, 1, 0, 0);
    lookup(9, 0, 0, K_EM, 0, "R9 absent block store");
    lookup(1, 0, 0, K_HIT, 0, "R9 other block untouched");
    // R10 / R11
    store(1, 0, 1, 0, 1, 3'd1);
    lookup(1, 0, 1, K_HIT, 0, "R10 speculative zero store");
    store(1, 0, 1, 0, 1, 3'd2);
    store(1, 0, 3, 0, 1, 3'd1);
    lookup(1, 0, 3, K_HIT, 0, "R10 second word");
    squash(3'd1);
    lookup(1, 0, 1, K_DM, 0, "R11 squash restores word1");
    lookup(1, 0, 3, K_DM, 0, "R11 squash restores word3");
    store(1, 0, 5, 0, 1, 3'd3);
    store(1, 0, 5, 0, 1, 3'd3);
    squash(3'd3);
    lookup(1, 0, 5, K_DM, 1, "R11 oldest value wins");
    store(1, 0, 6, 0, 1, 3'd4);
    store(1, 0, 7, 0, 1, 3'd5);
    squash(3'd4);
    lookup(1, 0, 6, K_DM, 1, "R11 matching id restored");
    lookup(1, 0, 7, K_HIT, 0, "R11 other id kept");
    // R12
    commit(3'd5);
    squash(3'd5);
    lookup(1, 0, 7, K_HIT, 0, "R12 squash after commit");
    commit(3'd2);
    lookup(1, 0, 1, K_DM, 0, "R12 commit leaves flags");
    // R13
    for (int w = 8; w < 16; w++) store(1, 0, w, 0, 1, 3'd6);
    store(1, 0, 4, 0, 1, 3'd6);
    lookup(1, 0, 4, K_DM, 1, "R13 full log rejects");
    lookup(1, 0, 8, K_HIT, 0, "R13 logged store applied");
    squash(3'd6);
    lookup(1, 0, 8, K_DM, 1, "R13 squash full log word8");
    lookup(1, 0, 15, K_DM, 1, "R13 squash full log word15");
    // R7 / R8
    fill(2, 1, 16'hFFFF, 4'hF);
    fill(3, 1, 16'hFFFF, 4'hF);
    lookup(3, 1, 0, K_HIT, 0, "R7 second way used");
    lookup(2, 1, 0, K_HIT, 0, "R7 first way kept");
    fill(4, 1, 16'hFFFF, 4'hF);
    lookup(3, 1, 0, K_EM, 0, "R8 LRU evicted");
    lookup(2, 1, 0, K_HIT, 0, "R8 MRU survives");
    lookup(4, 1, 0, K_HIT, 0, "R8 new block present");
    fill(2, 1, 16'h0000, 4'h0);
    lookup(2, 1, 0, K_DM, 1, "R7 refill overwrites");
    lookup(4, 1, 0, K_HIT, 0, "R7 refill keeps neighbour");
    // R14
    fill(5, 2, 16'h0000, 4'h0);
    store(5, 2, 0, 0, 1, 3'd7);
    lookup(5, 2, 0, K_HIT, 0, "R14 spec store before refill");
    fill(5, 2, 16'hFFFF, 4'hF);
    squash(3'd7);
    lookup(5, 2, 0, K_HIT, 0, "R14 refill drops log");
    repeat (3) @(negedge clk);
    check(rsp_valid == 0, "R2 idle no response", rsp_valid, 0);
    check(exp_kind_q.size() == 0, "R2 all responses seen", exp_kind_q.size(), 0);
    report();
  end
endmodule